// File: doc/BRIEF.md
# Infrared PHY Mode Configuration Gate

This block keeps the mode configuration that software writes for an infrared physical layer and decides when that configuration reaches the running PHY. Software selects a speed class (slow, medium or fast serial infrared) and a CRC16 option. It also prepares a packed control word for the next PHY setting, holding baud divisor, pulse width and preamble length fields. None of this touches the running PHY until software raises the IR enable bit from 0 to 1. At that edge the selected mode and the prepared control word are committed together.

A request that selects no speed class or more than one is never applied. The previous active mode stays in force, and a read-only error flag is raised. The next valid commit clears it. Software reads back the enable state, the error flag and the active mode through a status register. Whenever the PHY is disabled, the mode status bits read as zero. For the slow mode, software computes the baud field as 115200 divided by the bit rate, minus one. For the medium mode it writes zero. The block stores the word and does not interpret it.

Top module: `ir_mode_gate`

## Requirements
- R1: After reset every register reads 0x0000 and every output pin is 0.
- R2: The mode register (address 0) holds slow in bit 0, medium in bit 1, fast in bit 2 and CRC16 in bit 3, and reads back bits 15:4 as 0. The next-PHY register (address 2) reads back all 16 written bits, packed as baud [15:10], pulse width [9:5] and preamble [4:0].
- R3: Writing the mode register while the PHY is enabled leaves the active mode and the status bits unchanged until the next 0-to-1 transition of the enable bit.
- R4: At a valid commit (exactly one speed bit set), the status register (address 1) reports the mode from the following cycle, with fast-on at bit 13, medium-on at bit 12, slow-on at bit 11 and CRC16-on at bit 10. The matching output pins follow the same values, and at most one speed status is ever set.
- R5: A commit with zero or several speed bits set keeps the previous active mode and PHY word and sets the error flag (bit 14, pin cfg_error). The flag stays set until the next commit.
- R6: A valid commit clears the error flag.
- R7: While the enable bit (bit 15) is 0, all mode status bits and pins read 0. The error flag is still reported.
- R8: The active PHY word (read at address 3, and on pins phy_baud, phy_width, phy_preamble) is copied from the next-PHY register only at a valid commit, in the same cycle as the mode.
- R9: Writing 1 to the enable bit while it is already 1 is not a commit.
- R10: Writes to the read-only status bits 14:0 of address 1 have no effect.
- R11: Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| phy_enable | output | 1 | IR enable bit state |
| cfg_error | output | 1 | Configuration error flag |
| sir_on | output | 1 | Slow mode active and enabled |
| mir_on | output | 1 | Medium mode active and enabled |
| fir_on | output | 1 | Fast mode active and enabled |
| crc16_on | output | 1 | CRC16 option active and enabled |
| phy_baud | output | 6 | Active baud divisor field |
| phy_width | output | 5 | Active pulse width field |
| phy_preamble | output | 5 | Active preamble field |

## Verification
The commit path is driven with each single speed selection, with an empty selection and with a two-bit selection. The valid cases show whether the right status bit appears. The invalid cases show whether the previous mode is held and the error flag is raised. Configuration and next-PHY writes are made both while enabled and while disabled, and enable is rewritten while already set. This separates a true rising-edge commit from a level-sensitive or write-triggered one. Writes to read-only bits and to the active-word address confirm that nothing except the enable edge moves the active state.

// File: rtl/ir_mode_gate_pkg.sv
package ir_mode_gate_pkg;
  localparam int DATA_W   = 16;
  localparam int BAUD_W   = 6;
  localparam int PWID_W   = 5;
  localparam int PRE_W    = 5;
  localparam int MODE_W   = 4;

  localparam int ST_EN_BIT   = 15;
  localparam int ST_ERR_BIT  = 14;
  localparam int ST_FAST_BIT = 13;
  localparam int ST_MED_BIT  = 12;
  localparam int ST_SLOW_BIT = 11;
  localparam int ST_CRC_BIT  = 10;

  localparam logic [1:0] A_MODE   = 2'd0;
  localparam logic [1:0] A_STATUS = 2'd1;
  localparam logic [1:0] A_NEXT   = 2'd2;
  localparam logic [1:0] A_ACTIVE = 2'd3;

  typedef struct packed {
    logic crc16;
    logic fast;
    logic med;
    logic slow;
  } mode_sel_t;

  typedef struct packed {
    logic [BAUD_W-1:0] baud;
    logic [PWID_W-1:0] width;
    logic [PRE_W-1:0]  pre;
  } phy_word_t;

  function automatic logic speed_is_single(input mode_sel_t m);
    return (m.slow ^ m.med ^ m.fast) & ~(m.slow & m.med & m.fast);
  endfunction

  function automatic logic [DATA_W-1:0] status_word(
      input logic en, input logic err, input mode_sel_t shown);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ST_EN_BIT]   = en;
    w[ST_ERR_BIT]  = err;
    w[ST_FAST_BIT] = shown.fast;
    w[ST_MED_BIT]  = shown.med;
    w[ST_SLOW_BIT] = shown.slow;
    w[ST_CRC_BIT]  = shown.crc16;
    return w;
  endfunction
endpackage

// File: rtl/ir_mode_gate_regs.sv
module ir_mode_gate_regs
  import ir_mode_gate_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output mode_sel_t         mode_req,
  output phy_word_t         next_word
);
  logic wr_mode, wr_next;
  assign wr_mode = wr_en && (addr == ADDR_W'(A_MODE));
  assign wr_next = wr_en && (addr == ADDR_W'(A_NEXT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_req  <= '0;
      next_word <= '0;
    end else begin
      if (wr_mode) mode_req  <= mode_sel_t'(wdata[MODE_W-1:0]);
      if (wr_next) next_word <= phy_word_t'(wdata);
    end
  end
endmodule

// File: rtl/ir_mode_gate_commit.sv
module ir_mode_gate_commit
  import ir_mode_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_wr,
  input  logic      en_bit,
  input  mode_sel_t mode_req,
  input  phy_word_t next_word,
  output logic      en_q,
  output logic      err_q,
  output mode_sel_t act_mode,
  output phy_word_t act_word,
  output logic      commit,
  output logic      commit_ok
);
  logic req_ok;
  assign req_ok    = speed_is_single(mode_req);
  assign commit    = en_wr && en_bit && !en_q;
  assign commit_ok = commit && req_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      err_q    <= 1'b0;
      act_mode <= '0;
      act_word <= '0;
    end else begin
      if (en_wr) en_q <= en_bit;
      if (commit) begin
        if (req_ok) begin
          act_mode <= mode_req;
          act_word <= next_word;
          err_q    <= 1'b0;
        end else begin
          err_q    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ir_mode_gate_status.sv
module ir_mode_gate_status
  import ir_mode_gate_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              en_q,
  input  logic              err_q,
  input  mode_sel_t         act_mode,
  input  phy_word_t         act_word,
  input  mode_sel_t         mode_req,
  input  phy_word_t         next_word,
  input  logic [ADDR_W-1:0] addr,
  output mode_sel_t         shown,
  output logic [DATA_W-1:0] rdata
);
  assign shown = en_q ? act_mode : '0;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_MODE))        rdata = DATA_W'(mode_req);
    else if (addr == ADDR_W'(A_STATUS)) rdata = status_word(en_q, err_q, shown);
    else if (addr == ADDR_W'(A_NEXT))   rdata = next_word;
    else if (addr == ADDR_W'(A_ACTIVE)) rdata = act_word;
  end
endmodule

// File: rtl/ir_mode_gate.sv
module ir_mode_gate
  import ir_mode_gate_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              phy_enable,
  output logic              cfg_error,
  output logic              sir_on,
  output logic              mir_on,
  output logic              fir_on,
  output logic              crc16_on,
  output logic [5:0]        phy_baud,
  output logic [4:0]        phy_width,
  output logic [4:0]        phy_preamble
);
  mode_sel_t mode_req, act_mode, shown;
  phy_word_t next_word, act_word;
  logic en_q, err_q, commit_w, commit_ok_w, en_wr;

  assign en_wr = wr_en && (addr == ADDR_W'(A_STATUS));

  ir_mode_gate_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mode_req(mode_req), .next_word(next_word)
  );

  ir_mode_gate_commit u_commit (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_bit(wdata[ST_EN_BIT]),
    .mode_req(mode_req), .next_word(next_word), .en_q(en_q), .err_q(err_q),
    .act_mode(act_mode), .act_word(act_word), .commit(commit_w),
    .commit_ok(commit_ok_w)
  );

  ir_mode_gate_status #(.ADDR_W(ADDR_W)) u_status (
    .en_q(en_q), .err_q(err_q), .act_mode(act_mode), .act_word(act_word),
    .mode_req(mode_req), .next_word(next_word), .addr(addr),
    .shown(shown), .rdata(rdata)
  );

  assign phy_enable   = en_q;
  assign cfg_error    = err_q;
  assign sir_on       = shown.slow;
  assign mir_on       = shown.med;
  assign fir_on       = shown.fast;
  assign crc16_on     = shown.crc16;
  assign phy_baud     = act_word.baud;
  assign phy_width    = act_word.width;
  assign phy_preamble = act_word.pre;
endmodule

// File: rtl/ir_mode_gate_chk.sv
module ir_mode_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        commit,
  input logic        commit_ok,
  input logic        en_q,
  input logic        err_q,
  input logic [3:0]  act_mode,
  input logic [15:0] act_word,
  input logic        sir_on,
  input logic        mir_on,
  input logic        fir_on,
  input logic        crc16_on
);
  assert_mode_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_mode));
  assert_word_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_word));
  assert_bad_sets_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !commit_ok) |=> err_q);
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(err_q));
  assert_good_clears_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |=> !err_q);
  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !(sir_on || mir_on || fir_on || crc16_on));
  assert_single_speed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sir_on, mir_on, fir_on}));
  assert_edge_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !en_q);
endmodule

bind ir_mode_gate ir_mode_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit_w), .commit_ok(commit_ok_w),
  .en_q(en_q), .err_q(err_q), .act_mode(act_mode), .act_word(act_word),
  .sir_on(sir_on), .mir_on(mir_on), .fir_on(fir_on), .crc16_on(crc16_on)
);

// File: tb/ir_mode_gate_test.sv
module ir_mode_gate_test;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic phy_enable, cfg_error, sir_on, mir_on, fir_on, crc16_on;
  logic [5:0] phy_baud;
  logic [4:0] phy_width, phy_preamble;

  always #4 clk = ~clk;

  ir_mode_gate uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .phy_enable(phy_enable), .cfg_error(cfg_error),
    .sir_on(sir_on), .mir_on(mir_on), .fir_on(fir_on), .crc16_on(crc16_on),
    .phy_baud(phy_baud), .phy_width(phy_width), .phy_preamble(phy_preamble)
  );

  typedef struct {
    bit          pins;
    logic [1:0]  a;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit pend = 0;
  bit done = 0;

  logic [3:0]  m_cfg = 0, m_act = 0;
  logic        m_en = 0, m_err = 0;
  logic [15:0] m_next = 0, m_word = 0;

  function automatic bit one_speed(input logic [3:0] c);
    int n = 0;
    for (int i = 0; i < 3; i++) if (c[i]) n++;
    return n == 1;
  endfunction

  function automatic logic [15:0] m_status();
    logic [15:0] s = 16'h0;
    s[15] = m_en; s[14] = m_err;
    s[13] = m_en & m_act[2]; s[12] = m_en & m_act[1];
    s[11] = m_en & m_act[0]; s[10] = m_en & m_act[3];
    return s;
  endfunction

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {12'h0, m_cfg};
      2'd1: return m_status();
      2'd2: return m_next;
      default: return m_word;
    endcase
  endfunction

  task automatic m_write(input logic [1:0] a, input logic [15:0] d);
    if (a == 2'd0) m_cfg = d[3:0];
    else if (a == 2'd2) m_next = d;
    else if (a == 2'd1) begin
      if (d[15] && !m_en) begin
        if (one_speed(m_cfg)) begin m_act = m_cfg; m_word = m_next; m_err = 0; end
        else m_err = 1;
      end
      m_en = d[15];
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    pend = 0; wr_en = 1; addr = a; wdata = d;
    m_write(a, d);
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    item_t it;
    @(posedge clk); #1;
    wr_en = 0; addr = a;
    it.pins = 0; it.a = a; it.exp = m_read(a); it.tag = tag;
    sb.push_back(it); pend = 1;
  endtask

  task automatic pins(input string tag);
    item_t it;
    @(posedge clk); #1;
    wr_en = 0;
    it.pins = 1; it.a = addr; it.exp = {m_status()[15:10], m_word[9:0]}; it.tag = tag;
    it.exp[9:0] = m_word[9:0];
    sb.push_back(it); pend = 1;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    pend = 0;
  endtask

  always @(negedge clk) begin
    if (pend && sb.size() > 0) begin
      item_t it;
      logic [15:0] got, want;
      it = sb.pop_front();
      checks++;
      if (it.pins) begin
        got  = {phy_enable, cfg_error, fir_on, mir_on, sir_on, crc16_on,
                phy_width, phy_preamble};
        want = it.exp;
        if ({phy_baud} != m_word[15:10] && it.tag != "") begin
          errors++;
          $display("FAIL %s baud pins actual %h expected %h", it.tag, phy_baud, m_word[15:10]);
        end
      end else begin
        got = rdata; want = it.exp;
      end
      if (got !== want) begin
        errors++;
        $display("FAIL %s addr %0d actual %h expected %h", it.tag, it.a, got, want);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset values
    for (int a = 0; a < 4; a++) rd(2'(a), "R1");
    pins("R1");
    // R2: readback and masking of unused bits
    wr(2'd0, 16'hFFFF); rd(2'd0, "R2");
    wr(2'd0, 16'h0001); rd(2'd0, "R2");
    wr(2'd2, 16'hA5C3); rd(2'd2, "R2");
    // R10: read-only status bits ignore writes
    wr(2'd1, 16'h7C00); rd(2'd1, "R10");
    // R4 R8: slow mode commit
    wr(2'd1, 16'h8000); rd(2'd1, "R4"); rd(2'd3, "R8"); pins("R4");
    // R3: change request while enabled, no effect
    wr(2'd0, 16'h000A); wr(2'd2, 16'h0012);
    rd(2'd1, "R3"); rd(2'd3, "R3"); pins("R3");
    // R9: rewrite enable while set
    wr(2'd1, 16'h8000); rd(2'd1, "R9"); rd(2'd3, "R9");
    // R7: disabled hides mode
    wr(2'd1, 16'h0000); rd(2'd1, "R7"); pins("R7");
    // R4 R8: medium with CRC
    wr(2'd1, 16'h8000); rd(2'd1, "R4"); rd(2'd3, "R8"); pins("R4");
    // R5: two speed bits
    wr(2'd1, 16'h0000); wr(2'd0, 16'h0005); wr(2'd2, 16'h7777);
    wr(2'd1, 16'h8000); rd(2'd1, "R5"); rd(2'd3, "R5"); pins("R5");
    // R5: no speed bits
    wr(2'd1, 16'h0000); wr(2'd0, 16'h0000); wr(2'd1, 16'h8000);
    rd(2'd1, "R5"); pins("R5");
    // R7: error still reported while off
    wr(2'd1, 16'h0000); rd(2'd1, "R7");
    // R6: fast mode clears the error
    wr(2'd0, 16'h0004); wr(2'd1, 16'h8000);
    rd(2'd1, "R6"); rd(2'd3, "R6"); pins("R6");
    // R11: active address is read-only
    wr(2'd3, 16'hFFFF); rd(2'd3, "R11"); pins("R11");
    idle(); idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule